// File: doc/BRIEF.md
# Blanked Cycle-by-Cycle Current Limiter

This block sits between a PWM modulator and the gate driver of a switching regulator. For each switching period it watches two digitized, already-synchronized comparator bits. One is an ordinary current-limit comparator and the other is a hard-short comparator. It passes the PWM request through to a registered drive output. After the period's first drive edge, the current-limit bit is masked for a programmable number of clocks so that the turn-on spike cannot trip it. Once that window closes, a limit trip ends the on-pulse for the rest of the period. The hard-short bit has its own, separately programmed mask window. When it fires, the drive is forced off within one clock and stays off until a restart controller releases the block.

The block counts consecutive periods that ended in a limit trip. When the count reaches a programmed threshold, the block stops chopping pulses and instead raises a persistent-overcurrent request. The drive then stays off until the restart controller clears it, which hands the rail over to a hiccup-style restart. A two-bit sticky event field records which kind of event happened last. Software clears it with write-one-to-clear strobes.

The mask windows are counted in clock cycles. At a 125 MHz clock, programming 15 gives about 120 ns. The 5-bit default width reaches 248 ns, which covers the 80 to 200 ns range such rails need.

Top module: `cbc_current_limiter`

## Requirements
- R1: While reset is high, and on the first sample after it, gate_drv, short_fault and persist_oc are 0 and evt_flags is 2'b00.
- R2: With no trip and no held fault, gate_drv equals pwm_req delayed by exactly one clock.
- R3: A period starts at the first clock edge that samples pwm_req high after it was low. ilim_cmp is ignored on that edge and on the following cfg_blank-1 edges, so it is ignored on cfg_blank edges in all. A cfg_blank of 0 leaves the first edge unmasked.
- R4: When ilim_cmp is sampled high on an unmasked edge while pwm_req is high, gate_drv goes low after that edge. It then stays low until pwm_req is next sampled low and later high again.
- R5: When short_cmp is sampled high on an edge outside its own mask window, gate_drv goes low and short_fault goes high after that same edge. That window is cfg_short_blank edges from the period start, counted the same way as in R3.
- R6: short_fault and the forced-off drive stay held until an edge that samples fault_clear high. Later pwm_req pulses produce no drive in the meantime.
- R7: When a limit trip ends cfg_persist_n consecutive periods, persist_oc goes high after the edge of the last trip. gate_drv then stays low until fault_clear is sampled high, which also zeroes the count. A threshold of 0 acts as 1.
- R8: A period that ends without a limit trip resets the consecutive count, so the next trip counts as the first.
- R9: evt_flags bit 0 marks a limit event and bit 1 marks a hard-short event. A new event sets its own bit and clears the other. If both occur on the same edge, the short event wins (2'b10).
- R10: An edge that samples clr_we high clears each evt_flags bit whose clr_mask bit is 1 and leaves the other bit unchanged. A new event on the same edge takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_req | input | 1 | On request from the PWM modulator |
| ilim_cmp | input | 1 | Current-limit comparator bit |
| short_cmp | input | 1 | Hard-short comparator bit |
| cfg_blank | input | BLANK_W | Limit mask window in clocks (0 disables) |
| cfg_short_blank | input | BLANK_W | Hard-short mask window in clocks (0 disables) |
| cfg_persist_n | input | CNT_W | Consecutive limited periods that raise persist_oc |
| fault_clear | input | 1 | Release from the restart controller |
| clr_we | input | 1 | Write-one-to-clear strobe for evt_flags |
| clr_mask | input | 2 | Bits of evt_flags to clear |
| gate_drv | output | 1 | Registered drive to the gate driver |
| short_fault | output | 1 | Held hard-short fault request |
| persist_oc | output | 1 | Held persistent-overcurrent request |
| evt_flags | output | 2 | Sticky last-event record {short, limit} |

## Verification
The bench sweeps where the limit comparator rises relative to the end of the mask window. It covers a rise one clock before the window ends, a rise exactly at its end, a zero-length window, and a window that outlasts the pulse. An off-by-one in the mask counter would show up as a drive pulse one clock long or short, or as a trip on the spike edge. The bench also checks that a hard short holds the drive off across later pulses, and that a clean period between trips restarts the persistence count. A design that reset the count on every PWM edge, or never reset it, would raise persist_oc on the wrong period. The sticky flags are checked for short-over-limit priority, for the masked write-one-to-clear, and for an event arriving on the same edge as a clear, which a wrongly ordered design would lose.

// File: rtl/cbcl_pkg.sv
package cbcl_pkg;
  // comparator channel indices
  localparam int CH_LIM   = 0;
  localparam int CH_SHORT = 1;
  localparam int NUM_CH   = 2;
  // event flag bit positions
  localparam int FLG_LIM   = 0;
  localparam int FLG_SHORT = 1;
  localparam int FLG_W     = 2;
  typedef logic [FLG_W-1:0] evt_t;
endpackage

// File: rtl/cbcl_blank_window.sv
module cbcl_blank_window #(
  parameter int BLANK_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [BLANK_W-1:0] len,
  output logic               masked
);
  logic [BLANK_W-1:0] remain;

  // The start edge itself counts as the first masked edge.
  assign masked = start ? (len != '0) : (remain != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (start) begin
      remain <= (len == '0) ? '0 : len - 1'b1;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/cbcl_persist_count.sv
module cbcl_persist_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             prev_cut,
  input  logic             new_trip,
  input  logic             release_i,
  input  logic [CNT_W-1:0] thresh,
  output logic             persist
);
  logic [CNT_W-1:0] run_len;
  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   bumped;

  // A period that ended untripped restarts the run.
  assign base   = (start && !prev_cut) ? '0 : run_len;
  assign bumped = {1'b0, base} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || release_i) begin
      run_len <= '0;
      persist <= 1'b0;
    end else if (!persist) begin
      if (new_trip) begin
        run_len <= bumped[CNT_W-1:0];
        if (bumped >= {1'b0, thresh}) persist <= 1'b1;
      end else begin
        run_len <= base;
      end
    end
  end
endmodule

// File: rtl/cbcl_event_log.sv
module cbcl_event_log
  import cbcl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lim_evt,
  input  logic short_evt,
  input  logic clr_we,
  input  evt_t clr_mask,
  output evt_t flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (short_evt) begin
      flags <= evt_t'(1) << FLG_SHORT;
    end else if (lim_evt) begin
      flags <= evt_t'(1) << FLG_LIM;
    end else if (clr_we) begin
      flags <= flags & ~clr_mask;
    end
  end
endmodule

// File: rtl/cbc_current_limiter.sv
module cbc_current_limiter
  import cbcl_pkg::*;
#(
  parameter int BLANK_W = 5,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwm_req,
  input  logic               ilim_cmp,
  input  logic               short_cmp,
  input  logic [BLANK_W-1:0] cfg_blank,
  input  logic [BLANK_W-1:0] cfg_short_blank,
  input  logic [CNT_W-1:0]   cfg_persist_n,
  input  logic               fault_clear,
  input  logic               clr_we,
  input  logic [1:0]         clr_mask,
  output logic               gate_drv,
  output logic               short_fault,
  output logic               persist_oc,
  output logic [1:0]         evt_flags
);
  logic               pwm_q;
  logic               cut_q;
  logic               period_start;
  logic [BLANK_W-1:0] win_len [NUM_CH];
  logic [NUM_CH-1:0]  win_masked;
  logic               cut_cur;
  logic               held;
  logic               lim_raw;
  logic               lim_new;
  logic               short_trip;
  logic               short_new;
  logic               gate_next;

  assign period_start     = pwm_req & ~pwm_q;
  assign win_len[CH_LIM]   = cfg_blank;
  assign win_len[CH_SHORT] = cfg_short_blank;

  // one mask window per comparator channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_win
    cbcl_blank_window #(.BLANK_W(BLANK_W)) u_win (
      .clk    (clk),
      .rst    (rst),
      .start  (period_start),
      .len    (win_len[ch]),
      .masked (win_masked[ch])
    );
  end

  assign cut_cur    = cut_q & ~period_start;
  assign held       = (short_fault | persist_oc) & ~fault_clear;
  assign lim_raw    = ilim_cmp & pwm_req & ~win_masked[CH_LIM];
  assign lim_new    = lim_raw & ~cut_cur & ~short_fault & ~persist_oc;
  assign short_trip = short_cmp & ~win_masked[CH_SHORT];
  assign short_new  = short_trip & ~short_fault;
  assign gate_next  = pwm_req & ~cut_cur & ~lim_raw & ~short_trip & ~held;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q       <= 1'b0;
      cut_q       <= 1'b0;
      gate_drv    <= 1'b0;
      short_fault <= 1'b0;
    end else begin
      pwm_q       <= pwm_req;
      cut_q       <= cut_cur | lim_raw;
      gate_drv    <= gate_next;
      short_fault <= short_trip | (short_fault & ~fault_clear);
    end
  end

  cbcl_persist_count #(.CNT_W(CNT_W)) u_persist (
    .clk       (clk),
    .rst       (rst),
    .start     (period_start),
    .prev_cut  (cut_q),
    .new_trip  (lim_new),
    .release_i (fault_clear),
    .thresh    (cfg_persist_n),
    .persist   (persist_oc)
  );

  cbcl_event_log u_log (
    .clk       (clk),
    .rst       (rst),
    .lim_evt   (lim_new),
    .short_evt (short_new),
    .clr_we    (clr_we),
    .clr_mask  (clr_mask),
    .flags     (evt_flags)
  );
endmodule

// File: rtl/cbcl_checker.sv
module cbcl_checker #(
  parameter int BLANK_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               pwm_req,
  input logic               short_cmp,
  input logic [BLANK_W-1:0] cfg_blank,
  input logic               fault_clear,
  input logic               gate_drv,
  input logic               short_fault,
  input logic               persist_oc,
  input logic [1:0]         evt_flags
);
  // R2: drive only follows a sampled request
  assert_gate_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    gate_drv |-> $past(pwm_req));

  // R3: the turn-on edge is masked when a window is programmed
  assert_blank_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (pwm_req && !$past(pwm_req) && cfg_blank != '0 && !short_cmp
     && !short_fault && !persist_oc) |=> gate_drv);

  // R5: a new hard-short fault never coexists with drive
  assert_short_gate_off_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(short_fault) |-> !gate_drv);

  // R6: fault held until released
  assert_short_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (short_fault && !fault_clear) |=> short_fault);

  // R7: persistent overcurrent keeps the drive off
  assert_persist_gate_off_R7: assert property (@(posedge clk) disable iff (rst)
    persist_oc |-> !gate_drv);

  // R7: persistent request is held until released
  assert_persist_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (persist_oc && !fault_clear) |=> persist_oc);

  // R9: only the last event kind is recorded
  assert_flags_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evt_flags));
endmodule

bind cbc_current_limiter cbcl_checker #(.BLANK_W(BLANK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwm_req     (pwm_req),
  .short_cmp   (short_cmp),
  .cfg_blank   (cfg_blank),
  .fault_clear (fault_clear),
  .gate_drv    (gate_drv),
  .short_fault (short_fault),
  .persist_oc  (persist_oc),
  .evt_flags   (evt_flags)
);

// File: tb/sim_cbc_current_limiter.sv
`timescale 1ns/1ps
module sim_cbc_current_limiter;
  localparam int BLANK_W = 5;
  localparam int CNT_W   = 4;
  localparam int NEVER   = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_req = 1'b0, ilim_cmp = 1'b0, short_cmp = 1'b0;
  logic [BLANK_W-1:0] cfg_blank = 5'd15, cfg_short_blank = 5'd2;
  logic [CNT_W-1:0] cfg_persist_n = 4'd8;
  logic fault_clear = 1'b0, clr_we = 1'b0;
  logic [1:0] clr_mask = 2'b00;
  logic gate_drv, short_fault, persist_oc;
  logic [1:0] evt_flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  cbc_current_limiter #(.BLANK_W(BLANK_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .pwm_req(pwm_req), .ilim_cmp(ilim_cmp),
    .short_cmp(short_cmp), .cfg_blank(cfg_blank),
    .cfg_short_blank(cfg_short_blank), .cfg_persist_n(cfg_persist_n),
    .fault_clear(fault_clear), .clr_we(clr_we), .clr_mask(clr_mask),
    .gate_drv(gate_drv), .short_fault(short_fault),
    .persist_oc(persist_oc), .evt_flags(evt_flags)
  );

  typedef struct packed {
    logic       is_short;
    logic [4:0] win;
    logic [7:0] t_on;
    logic [7:0] len;
    logic [7:0] exp_hi;
    logic [1:0] exp_flg;
  } vec_t;

  // expected high clocks = min(max(t_on, win), len)
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd15, 8'd0,  8'd30, 8'd15, 2'b01},
    '{1'b0, 5'd15, 8'd20, 8'd30, 8'd20, 2'b01},
    '{1'b0, 5'd15, 8'd5,  8'd10, 8'd10, 2'b00},
    '{1'b0, 5'd0,  8'd0,  8'd10, 8'd0,  2'b01},
    '{1'b0, 5'd0,  8'd3,  8'd10, 8'd3,  2'b01},
    '{1'b0, 5'd3,  8'd0,  8'd10, 8'd3,  2'b01},
    '{1'b0, 5'd15, 8'd14, 8'd20, 8'd15, 2'b01},
    '{1'b0, 5'd31, 8'd40, 8'd50, 8'd40, 2'b01},
    '{1'b0, 5'd5,  8'd9,  8'd9,  8'd9,  2'b00},
    '{1'b1, 5'd4,  8'd0,  8'd20, 8'd4,  2'b10},
    '{1'b1, 5'd0,  8'd0,  8'd10, 8'd0,  2'b10},
    '{1'b1, 5'd2,  8'd6,  8'd12, 8'd6,  2'b10},
    '{1'b1, 5'd8,  8'd0,  8'd5,  8'd5,  2'b00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_pulse(input int len, input int t_lim, input int t_sh,
                           output int hi);
    hi = 0;
    for (int i = 0; i <= len + 1; i++) begin
      @(negedge clk);
      if (i >= 1 && gate_drv) hi++;
      pwm_req   = (i < len);
      ilim_cmp  = (i >= t_lim) && (i < len);
      short_cmp = (i >= t_sh) && (i < len);
    end
    @(negedge clk);
  endtask

  task automatic release_all();
    @(negedge clk); clr_we = 1'b1; clr_mask = 2'b11;
    @(negedge clk); clr_we = 1'b0; clr_mask = 2'b00; fault_clear = 1'b1;
    @(negedge clk); fault_clear = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi;
    // R1: reset state, request high during reset must not drive
    pwm_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", gate_drv, 0);
    pwm_req = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 gate", gate_drv, 0);
    chk("R1 short_fault", short_fault, 0);
    chk("R1 persist_oc", persist_oc, 0);
    chk("R1 evt_flags", evt_flags, 0);

    // R2: one-clock latency pass-through
    cfg_persist_n = 4'd15;
    pwm_req = 1'b1;
    @(negedge clk); chk("R2 gate after first edge", gate_drv, 1);
    pwm_req = 1'b0;
    @(negedge clk); chk("R2 gate after fall", gate_drv, 0);
    run_pulse(7, NEVER, NEVER, hi);
    chk("R2 clean pulse width", hi, 7);

    // table walk: R3 R4 (limit) and R5 (short)
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].is_short) begin
        cfg_blank = 5'd0; cfg_short_blank = VECS[v].win;
        run_pulse(int'(VECS[v].len), NEVER, int'(VECS[v].t_on), hi);
        chk($sformatf("R5 short vec %0d width", v), hi, int'(VECS[v].exp_hi));
        chk($sformatf("R5 R9 short vec %0d flags", v), evt_flags,
            int'(VECS[v].exp_flg));
      end else begin
        cfg_short_blank = 5'd0; cfg_blank = VECS[v].win;
        run_pulse(int'(VECS[v].len), int'(VECS[v].t_on), NEVER, hi);
        chk($sformatf("R3 R4 limit vec %0d width", v), hi,
            int'(VECS[v].exp_hi));
        chk($sformatf("R4 R9 limit vec %0d flags", v), evt_flags,
            int'(VECS[v].exp_flg));
      end
      release_all();
    end

    // R6: hard-short fault holds drive off across pulses
    cfg_blank = 5'd2; cfg_short_blank = 5'd0;
    run_pulse(6, NEVER, 2, hi);
    chk("R6 tripped pulse width", hi, 2);
    run_pulse(6, NEVER, NEVER, hi);
    chk("R6 held pulse width", hi, 0);
    chk("R6 short_fault held", short_fault, 1);
    release_all();
    chk("R6 short_fault released", short_fault, 0);
    run_pulse(4, NEVER, NEVER, hi);
    chk("R6 pulse after release", hi, 4);

    // R7: three consecutive limited periods
    cfg_persist_n = 4'd3;
    for (int p = 0; p < 3; p++) begin
      run_pulse(8, 4, NEVER, hi);
      chk($sformatf("R7 limited period %0d width", p), hi, 4);
      chk($sformatf("R7 persist after period %0d", p), persist_oc,
          (p == 2) ? 1 : 0);
    end
    run_pulse(8, NEVER, NEVER, hi);
    chk("R7 drive off while persistent", hi, 0);
    release_all();
    chk("R7 persist released", persist_oc, 0);

    // R8: a clean period restarts the run
    run_pulse(8, 4, NEVER, hi);
    run_pulse(8, 4, NEVER, hi);
    run_pulse(8, NEVER, NEVER, hi);
    chk("R8 clean period width", hi, 8);
    run_pulse(8, 4, NEVER, hi);
    run_pulse(8, 4, NEVER, hi);
    chk("R8 no persist after reset run", persist_oc, 0);
    run_pulse(8, 4, NEVER, hi);
    chk("R8 persist on third of new run", persist_oc, 1);
    release_all();

    // R7: threshold 0 acts as 1
    cfg_persist_n = 4'd0;
    run_pulse(8, 4, NEVER, hi);
    chk("R7 threshold zero persist", persist_oc, 1);
    release_all();
    cfg_persist_n = 4'd15;

    // R9: short wins a tie, then a limit event replaces it
    cfg_blank = 5'd0; cfg_short_blank = 5'd0;
    run_pulse(5, 0, 0, hi);
    chk("R9 tie flags", evt_flags, 2);
    @(negedge clk); fault_clear = 1'b1;
    @(negedge clk); fault_clear = 1'b0;
    run_pulse(5, 1, NEVER, hi);
    chk("R9 limit replaces short", evt_flags, 1);

    // R10: masked clear and event-over-clear priority
    @(negedge clk); clr_we = 1'b1; clr_mask = 2'b10;
    @(negedge clk); clr_we = 1'b0;
    @(negedge clk); chk("R10 unmasked bit kept", evt_flags, 1);
    clr_we = 1'b1; clr_mask = 2'b01;
    @(negedge clk); clr_we = 1'b0;
    @(negedge clk); chk("R10 masked bit cleared", evt_flags, 0);
    pwm_req = 1'b1; ilim_cmp = 1'b1; clr_we = 1'b1; clr_mask = 2'b11;
    @(negedge clk); pwm_req = 1'b0; ilim_cmp = 1'b0; clr_we = 1'b0;
    @(negedge clk); chk("R10 event beats clear", evt_flags, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule